// File: doc/BRIEF.md
# JTAG Test Access Port with Core-Reset and Programming-Unlock Chains

This block is a JTAG test access port for a small microcontroller core. It runs the standard sixteen-state TAP machine from TCK, TMS, TDI and an asynchronous active-low test reset, and it returns serial data on TDO. A 4-bit instruction register selects one of three data paths between TDI and TDO:
- a one-bit BYPASS stage;
- a one-bit core-reset chain;
- a 16-bit programming-unlock register.

The core-reset chain is not latched. Whatever bit it holds drives the core reset output directly, so that output can change in the middle of a scan. Holding the core in reset this way never resets the TAP or its instruction register.

The programming-unlock register takes a 16-bit key. At Update-DR it raises the `prog_enabled` flag only when the key equals a fixed signature. Any other key lowers the flag.

The controller states are:

| State | Role |
|-------|------|
| TS_RESET | Test-Logic-Reset |
| TS_IDLE | Run-Test/Idle |
| TS_SEL_DR | Select-DR-Scan |
| TS_CAP_DR | Capture-DR |
| TS_SH_DR | Shift-DR |
| TS_EX1_DR | Exit1-DR |
| TS_PAU_DR | Pause-DR |
| TS_EX2_DR | Exit2-DR |
| TS_UPD_DR | Update-DR |
| TS_SEL_IR to TS_UPD_IR | The same seven states for the instruction register |

The transitions below are taken at each rising edge of TCK, with "1" meaning TMS high and "0" meaning TMS low:

| From | TMS = 1 | TMS = 0 |
|------|---------|---------|
| RESET | RESET | IDLE |
| IDLE | SEL_DR | IDLE |
| SEL_DR | SEL_IR | CAP_DR |
| SEL_IR | RESET | CAP_IR |
| CAP_x | EX1_x | SH_x |
| SH_x | EX1_x | SH_x |
| EX1_x | UPD_x | PAU_x |
| PAU_x | EX2_x | PAU_x |
| EX2_x | UPD_x | SH_x |
| UPD_x | SEL_DR | IDLE |

Top module: `jtag_tap_prog`

## Requirements
- R1: The state moves on each TCK rising edge according to the transition table. Five consecutive TMS-high edges reach TS_RESET from any state. A low `trst_n` forces TS_RESET asynchronously and clears `tdo_oe`, `core_reset` and `prog_enabled`.
- R2: A rising edge taken in TS_RESET has three effects. It loads the BYPASS opcode 4'b1111 into the active instruction. It clears `prog_enabled`. It clears the core-reset chain.
- R3: Capture-IR loads 4'b0001 into the instruction shifter. Shift-IR moves that value out on TDO least significant bit first, while TDI enters at the top. The active instruction changes only at Update-IR.
- R4: Opcode 4'hC places the one-bit core-reset chain between TDI and TDO. Each Shift-DR edge stores TDI in the chain. During that shift, TDO presents the bit held before the edge.
- R5: `core_reset` equals the core-reset chain bit. It changes on the very Shift-DR edge that stores a new bit, even when that edge leaves Shift-DR, and Update-DR plays no part.
- R6: While `core_reset` is high, instruction scans still capture 4'b0001. The active instruction also remains in force, so a later data scan returns the stored reset bit.
- R7: Opcode 4'h4 places a 16-bit unlock register between TDI and TDO, shifted least significant bit first. A value shifted in appears on TDO exactly 16 shifts later. The register keeps its contents through Capture-DR.
- R8: At Update-DR under opcode 4'h4, `prog_enabled` is set if the unlock register equals 16'hA370 and is cleared otherwise. Outside Update-DR under 4'h4 and TS_RESET, the flag holds its value.
- R9: Every other opcode selects the one-bit BYPASS stage. That stage loads 0 in Capture-DR and delays TDI by one shift.
- R10: TDO and `tdo_oe` are updated on the falling edge of TCK. `tdo_oe` is high exactly while the state is Shift-DR or Shift-IR. In every other state, TDO is driven to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on the rising edge of TCK |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on the falling edge of TCK |
| tdo_oe | output | 1 | High while TDO carries shift data |
| core_reset | output | 1 | Core reset, taken from the unlatched reset-chain bit |
| prog_enabled | output | 1 | Programming unlocked by a matching signature |

## Verification
The interesting overlap is the core-reset chain changing on the same TCK edge on which the TAP leaves Shift-DR. The bench provokes it by shifting the final reset bit with TMS high, so the store and the move to Exit1-DR happen together. It then checks that `core_reset` has already followed TDI before Update-DR is reached. A second overlap is the TS_RESET edge, which clears the instruction, the unlock flag and the reset chain in a single cycle. The bench drives it with five TMS-high edges while the reset chain holds a one and the flag is set, and confirms all three changes at the ports. A cycle-by-cycle model in the bench is compared against TDO, `tdo_oe`, `core_reset` and `prog_enabled` on every falling edge.

// File: rtl/jtp_pkg.sv
`timescale 1ns/1ps
package jtp_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    typedef struct packed {
        logic in_reset;
        logic cap_dr;
        logic sh_dr;
        logic upd_dr;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
    } tap_ctl_t;

endpackage

// File: rtl/jtp_fsm.sv
`timescale 1ns/1ps
module jtp_fsm
    import jtp_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output tap_ctl_t   ctl
);

    tap_state_t nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= TS_RESET;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt = TS_RESET;
        endcase
    end

    always_comb begin
        ctl          = '0;
        ctl.in_reset = (state == TS_RESET);
        ctl.cap_dr   = (state == TS_CAP_DR);
        ctl.sh_dr    = (state == TS_SH_DR);
        ctl.upd_dr   = (state == TS_UPD_DR);
        ctl.cap_ir   = (state == TS_CAP_IR);
        ctl.sh_ir    = (state == TS_SH_IR);
        ctl.upd_ir   = (state == TS_UPD_IR);
    end

endmodule

// File: rtl/jtp_ir.sv
`timescale 1ns/1ps
module jtp_ir
    import jtp_pkg::*;
#(
    parameter int IR_W = 4
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_ctl_t        ctl,
    output logic [IR_W-1:0] ir_q,
    output logic [IR_W-1:0] ir_sh
);

    localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-1){1'b0}}, 1'b1};
    localparam logic [IR_W-1:0] IR_BYPASS  = {IR_W{1'b1}};

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh <= '0;
        end else if (ctl.cap_ir) begin
            ir_sh <= IR_CAPTURE;
        end else if (ctl.sh_ir) begin
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)          ir_q <= IR_BYPASS;
        else if (ctl.in_reset) ir_q <= IR_BYPASS;
        else if (ctl.upd_ir)   ir_q <= ir_sh;
    end

endmodule

// File: rtl/jtp_dr.sv
`timescale 1ns/1ps
module jtp_dr
    import jtp_pkg::*;
#(
    parameter int              IR_W   = 4,
    parameter int              PE_W   = 16,
    parameter logic [PE_W-1:0] PE_SIG = 16'hA370,
    parameter logic [IR_W-1:0] OP_RST = 4'hC,
    parameter logic [IR_W-1:0] OP_PE  = 4'h4
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_ctl_t        ctl,
    input  logic [IR_W-1:0] ir_q,
    output logic            core_reset,
    output logic            prog_enabled,
    output logic            dr_lsb
);

    logic            sel_rst;
    logic            sel_pe;
    logic            sel_byp;
    logic            byp_q;
    logic            rst_q;
    logic [PE_W-1:0] pe_q;

    always_comb begin
        sel_rst = (ir_q == OP_RST);
        sel_pe  = (ir_q == OP_PE);
        sel_byp = !sel_rst && !sel_pe;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                  byp_q <= 1'b0;
        else if (sel_byp && ctl.cap_dr) byp_q <= 1'b0;
        else if (sel_byp && ctl.sh_dr)  byp_q <= tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                  rst_q <= 1'b0;
        else if (ctl.in_reset)        rst_q <= 1'b0;
        else if (sel_rst && ctl.sh_dr) rst_q <= tdi;
    end

    generate
        for (genvar g = 0; g < PE_W; g++) begin : g_pe
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n)                  pe_q[g] <= 1'b0;
                else if (sel_pe && ctl.sh_dr) begin
                    if (g == PE_W - 1) pe_q[g] <= tdi;
                    else               pe_q[g] <= pe_q[(g == PE_W - 1) ? g : g + 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                    prog_enabled <= 1'b0;
        else if (ctl.in_reset)          prog_enabled <= 1'b0;
        else if (sel_pe && ctl.upd_dr)  prog_enabled <= (pe_q == PE_SIG);
    end

    always_comb begin
        core_reset = rst_q;
        if (sel_rst)     dr_lsb = rst_q;
        else if (sel_pe) dr_lsb = pe_q[0];
        else             dr_lsb = byp_q;
    end

endmodule

// File: rtl/jtag_tap_prog.sv
`timescale 1ns/1ps
module jtag_tap_prog
    import jtp_pkg::*;
#(
    parameter int              IR_W   = 4,
    parameter int              PE_W   = 16,
    parameter logic [PE_W-1:0] PE_SIG = 16'hA370,
    parameter logic [IR_W-1:0] OP_RST = 4'hC,
    parameter logic [IR_W-1:0] OP_PE  = 4'h4
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic core_reset,
    output logic prog_enabled
);

    tap_state_t      tap_state;
    tap_ctl_t        ctl;
    logic [IR_W-1:0] ir_q;
    logic [IR_W-1:0] ir_sh;
    logic            dr_lsb;

    jtp_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (tap_state),
        .ctl    (ctl)
    );

    jtp_ir #(.IR_W(IR_W)) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .ctl    (ctl),
        .ir_q   (ir_q),
        .ir_sh  (ir_sh)
    );

    jtp_dr #(
        .IR_W   (IR_W),
        .PE_W   (PE_W),
        .PE_SIG (PE_SIG),
        .OP_RST (OP_RST),
        .OP_PE  (OP_PE)
    ) u_dr (
        .tck          (tck),
        .trst_n       (trst_n),
        .tdi          (tdi),
        .ctl          (ctl),
        .ir_q         (ir_q),
        .core_reset   (core_reset),
        .prog_enabled (prog_enabled),
        .dr_lsb       (dr_lsb)
    );

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= ctl.sh_dr || ctl.sh_ir;
            if (ctl.sh_ir)      tdo <= ir_sh[0];
            else if (ctl.sh_dr) tdo <= dr_lsb;
            else                tdo <= 1'b0;
        end
    end

endmodule

// File: rtl/jtp_chk.sv
`timescale 1ns/1ps
module jtp_chk
    import jtp_pkg::*;
#(
    parameter int              IR_W   = 4,
    parameter logic [IR_W-1:0] OP_RST = 4'hC
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            tdi,
    input tap_state_t      state,
    input logic [IR_W-1:0] ir_q,
    input logic [IR_W-1:0] ir_sh,
    input logic            core_reset,
    input logic            prog_enabled,
    input logic            tdo_oe
);

    logic [2:0] edges;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)          edges <= '0;
        else if (edges != 3'd5) edges <= edges + 3'd1;
    end

    a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
        (edges == 3'd5 && $past(tms, 1) && $past(tms, 2) && $past(tms, 3)
         && $past(tms, 4) && $past(tms, 5)) |-> state == TS_RESET);

    a_r2_reset_clears: assert property (@(posedge tck) disable iff (!trst_n)
        state == TS_RESET |=> (ir_q == {IR_W{1'b1}} && !prog_enabled && !core_reset));

    a_r3_capture_ir: assert property (@(posedge tck) disable iff (!trst_n)
        state == TS_CAP_IR |=> ir_sh == {{(IR_W-1){1'b0}}, 1'b1});

    a_r5_chain_unlatched: assert property (@(posedge tck) disable iff (!trst_n)
        (state == TS_SH_DR && ir_q == OP_RST) |=> core_reset == $past(tdi));

    a_r6_ir_held: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir_q));

    a_r8_flag_held: assert property (@(posedge tck) disable iff (!trst_n)
        (state != TS_UPD_DR && state != TS_RESET) |=> $stable(prog_enabled));

    a_r10_oe_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (state == TS_SH_DR || state == TS_SH_IR));

endmodule

bind jtag_tap_prog jtp_chk #(.IR_W(IR_W), .OP_RST(OP_RST)) chk_i (
    .tck          (tck),
    .trst_n       (trst_n),
    .tms          (tms),
    .tdi          (tdi),
    .state        (tap_state),
    .ir_q         (ir_q),
    .ir_sh        (ir_sh),
    .core_reset   (core_reset),
    .prog_enabled (prog_enabled),
    .tdo_oe       (tdo_oe)
);

// File: tb/jtag_tap_prog_tb_top.sv
`timescale 1ns/1ps
module jtag_tap_prog_tb_top;

    logic tck = 1'b0;
    logic trst_n;
    logic tms;
    logic tdi;
    logic tdo;
    logic tdo_oe;
    logic core_reset;
    logic prog_enabled;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 tck = ~tck;

    jtag_tap_prog dut_i (
        .tck          (tck),
        .trst_n       (trst_n),
        .tms          (tms),
        .tdi          (tdi),
        .tdo          (tdo),
        .tdo_oe       (tdo_oe),
        .core_reset   (core_reset),
        .prog_enabled (prog_enabled)
    );

    // Reference model state numbering (bench-local)
    localparam int M_TLR = 0, M_RTI = 1;
    localparam int M_SDR = 10, M_CDR = 11, M_SHD = 12, M_E1D = 13, M_PD = 14, M_E2D = 15, M_UD = 16;
    localparam int M_SIR = 20, M_CIR = 21, M_SHI = 22, M_E1I = 23, M_PI = 24, M_E2I = 25, M_UI = 26;

    int       ms;
    bit [3:0] m_ir;
    bit [3:0] m_irs;
    bit       m_rst;
    bit       m_byp;
    bit       m_flag;
    bit       m_pe[$];
    bit       m_tdo;
    bit       m_oe;

    function automatic int nstate(int s, bit m);
        case (s)
            M_TLR: return m ? M_TLR : M_RTI;
            M_RTI: return m ? M_SDR : M_RTI;
            M_SDR: return m ? M_SIR : M_CDR;
            M_SIR: return m ? M_TLR : M_CIR;
            M_CDR, M_SHD, M_E2D: return m ? ((s == M_E2D) ? M_UD : M_E1D) : M_SHD;
            M_CIR, M_SHI, M_E2I: return m ? ((s == M_E2I) ? M_UI : M_E1I) : M_SHI;
            M_E1D: return m ? M_UD : M_PD;
            M_PD:  return m ? M_E2D : M_PD;
            M_E1I: return m ? M_UI : M_PI;
            M_PI:  return m ? M_E2I : M_PI;
            M_UD, M_UI: return m ? M_SDR : M_RTI;
            default: return M_TLR;
        endcase
    endfunction

    function automatic bit [15:0] pe_val();
        bit [15:0] v = '0;
        foreach (m_pe[i]) v[i] = m_pe[i];
        return v;
    endfunction

    task automatic model_reset();
        ms = M_TLR; m_ir = 4'hF; m_irs = 4'h0; m_rst = 0; m_byp = 0; m_flag = 0;
        m_pe.delete();
        for (int i = 0; i < 16; i++) m_pe.push_back(1'b0);
        m_tdo = 0; m_oe = 0;
    endtask

    task automatic model_edge(bit m, bit d);
        case (ms)
            M_TLR: begin m_ir = 4'hF; m_flag = 0; m_rst = 0; end
            M_CIR: m_irs = 4'b0001;
            M_SHI: m_irs = {d, m_irs[3:1]};
            M_UI:  m_ir = m_irs;
            M_CDR: if (m_ir != 4'hC && m_ir != 4'h4) m_byp = 0;
            M_SHD: begin
                if (m_ir == 4'hC) m_rst = d;
                else if (m_ir == 4'h4) begin m_pe.push_back(d); void'(m_pe.pop_front()); end
                else m_byp = d;
            end
            M_UD: if (m_ir == 4'h4) m_flag = (pe_val() == 16'hA370);
            default: ;
        endcase
        ms = nstate(ms, m);
    endtask

    task automatic model_fall();
        m_oe = (ms == M_SHD || ms == M_SHI);
        if (ms == M_SHI) m_tdo = m_irs[0];
        else if (ms == M_SHD) m_tdo = (m_ir == 4'hC) ? m_rst : (m_ir == 4'h4) ? m_pe[0] : m_byp;
        else m_tdo = 0;
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(tdo_oe == m_oe, "R10", "tdo_oe", int'(tdo_oe), int'(m_oe));
        check(tdo == m_tdo, "R10", "tdo", int'(tdo), int'(m_tdo));
        check(core_reset == m_rst, "R5", "core_reset", int'(core_reset), int'(m_rst));
        check(prog_enabled == m_flag, "R8", "prog_enabled", int'(prog_enabled), int'(m_flag));
    endtask

    task automatic step(bit m, bit d);
        tms = m; tdi = d;
        @(posedge tck);
        model_edge(m, d);
        @(negedge tck);
        model_fall();
        #2;
        compare_all();
    endtask

    task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            step(i == 3, op[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [3:0]  cap;
        logic [31:0] dout;
        trst_n = 0; tms = 1; tdi = 0;
        model_reset();
        repeat (2) @(negedge tck);
        #2;
        trst_n = 1;
        check(core_reset == 0 && prog_enabled == 0 && tdo_oe == 0, "R2", "reset outputs",
              int'({core_reset, prog_enabled, tdo_oe}), 0);
        step(0, 0);

        // R3 / R9: bypass opcode 0x7, captured IR pattern, one-shift delay
        load_ir(4'h7, cap);
        check(cap == 4'b0001, "R3", "IR capture", cap, 4'b0001);
        scan_dr(4, 32'hB, dout);
        check(dout[3:0] == 4'b0110, "R9", "bypass out", dout[3:0], 4'b0110);

        // R5: reset chain changes on the exit edge of Shift-DR, before Update-DR
        load_ir(4'hC, cap);
        check(cap == 4'b0001, "R3", "IR capture C", cap, 4'b0001);
        step(1, 0); step(0, 0); step(0, 0);
        check(core_reset == 0, "R5", "before shift", core_reset, 0);
        step(1, 1);
        check(core_reset == 1, "R5", "at Exit1-DR", core_reset, 1);
        step(1, 0); step(0, 0);

        // R4: previous bit presented on TDO while shifting
        scan_dr(1, 32'h0, dout);
        check(dout[0] == 1, "R4", "old reset bit", dout[0], 1);
        check(core_reset == 0, "R4", "reset cleared", core_reset, 0);

        // R6: TAP keeps working under core reset
        scan_dr(1, 32'h1, dout);
        check(core_reset == 1, "R6", "reset set", core_reset, 1);
        load_ir(4'hC, cap);
        check(cap == 4'b0001, "R6", "IR capture under reset", cap, 4'b0001);
        check(core_reset == 1, "R6", "reset kept", core_reset, 1);
        scan_dr(1, 32'h0, dout);
        check(dout[0] == 1, "R6", "chain kept", dout[0], 1);

        // R7 / R8: unlock register
        load_ir(4'h4, cap);
        scan_dr(16, 32'hA370, dout);
        check(prog_enabled == 1, "R8", "good key", prog_enabled, 1);
        scan_dr(16, 32'h1234, dout);
        check(dout[15:0] == 16'hA370, "R7", "16-shift delay", dout[15:0], 16'hA370);
        check(prog_enabled == 0, "R8", "bad key", prog_enabled, 0);
        scan_dr(16, 32'hA370, dout);
        check(dout[15:0] == 16'h1234, "R7", "16-shift delay 2", dout[15:0], 16'h1234);
        load_ir(4'hC, cap);
        check(prog_enabled == 1, "R8", "flag held", prog_enabled, 1);

        // R1 / R2: five TMS-high edges from Shift-DR while reset chain is set
        step(1, 0); step(0, 0); step(0, 0);
        step(1, 1); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
        check(core_reset == 1, "R5", "set before TLR", core_reset, 1);
        step(0, 0);
        check(core_reset == 0 && prog_enabled == 0, "R2", "TLR clears",
              int'({core_reset, prog_enabled}), 0);
        scan_dr(2, 32'h1, dout);
        check(dout[1:0] == 2'b10, "R1", "bypass after TLR", dout[1:0], 2'b10);

        // R1: asynchronous test reset in the middle of a scan
        load_ir(4'h4, cap);
        scan_dr(16, 32'hA370, dout);
        step(1, 0); step(0, 0); step(0, 0);
        check(tdo_oe == 1, "R10", "oe in shift", tdo_oe, 1);
        trst_n = 0;
        #1;
        model_reset();
        check(tdo_oe == 0 && prog_enabled == 0, "R1", "async trst",
              int'({tdo_oe, prog_enabled}), 0);
        @(negedge tck);
        #2;
        trst_n = 1;
        step(0, 0);
        step(0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule